// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small system-on-chip between its running state and five low-power modes: IDLE, DEEP-IDLE, STOP, DEEP-STOP and SLEEP. Software picks a target mode and fills in two configuration words, one for the idle-type deep mode and one for the stop-type deep mode. Each word holds a 2-bit top-domain field and an L2-retention bit. Nothing changes until the CPU signals that it has entered standby after a wait-for-interrupt. At that moment the controller samples the mode and the matching configuration word. It then drives a per-domain pattern of clock and power enables.

A wakeup event starts a fixed restore sequence. All power enables come back first. They are followed by a settling window, then the PLL enable, then the clocks. The controller returns to NORMAL with a one-cycle completion pulse. The word "deep" means the CPU core loses power rather than only its clock. The top-domain field is read one way for DEEP-IDLE and another way for DEEP-STOP.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode reads NORMAL (cur_mode = 0), all eight enables are 1 and wake_done is 0.
- R2: Software writes a register by asserting cfg_we with cfg_sel. Selector 0 is the mode register, 1 is the idle configuration and 2 is the stop configuration. In a configuration word, bits [1:0] are the top field and bit 2 is L2 keep. Mode codes are 0 NORMAL, 1 IDLE, 2 DEEP-IDLE, 3 STOP, 4 DEEP-STOP and 5 SLEEP. A low-power mode is entered only on a cycle where cpu_standby is high and the mode register holds a code from 1 to 5. A mode write alone, or a code of 0, 6 or 7, leaves every output unchanged. The entered mode then shows on cur_mode in the next cycle.
- R3: In IDLE only cpu_clk_en is 0. Every other enable stays 1.
- R4: In DEEP-IDLE with idle top field 2'b01, cpu_clk_en, cpu_pwr_en and periph_clk_en are 0. The top, audio, PLL and RTC enables are 1, and l2_pwr_en equals the idle L2-keep bit.
- R5: In DEEP-IDLE with idle top field 2'b10 or a reserved value (2'b00, 2'b11), the enables match R4 except that periph_clk_en is 1.
- R6: In STOP, cpu_clk_en, pll_en and periph_clk_en are 0. The CPU, top, audio, L2 and RTC enables stay 1.
- R7: In DEEP-STOP, only rtc_clk_en is forced to 1, and the CPU, audio, PLL and peripheral enables are 0. top_pwr_en is 1 only for stop top field 2'b10; 2'b01 and the reserved values give 0. l2_pwr_en equals the stop L2-keep bit.
- R8: In SLEEP only rtc_clk_en is 1, whatever either configuration word holds.
- R9: The mode and configuration are captured at entry. Register writes made while in a low-power mode do not change the outputs until the next entry.
- R10: A wake_evt in a low-power mode starts a restore sequence. First, for 8 cycles, the power enables (CPU, top, audio, L2) are 1 and the PLL and clock enables keep their low-power values. Next comes one cycle with pll_en also 1. Last comes one cycle with every enable 1 and wake_done 1, followed by NORMAL. wake_evt while in NORMAL and cpu_standby while in a low-power mode have no effect.
- R11: cpu_clk_en is never 1 while cpu_pwr_en is 0, and periph_clk_en and cpu_clk_en are 0 whenever pll_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector: 0 mode, 1 idle config, 2 stop config |
| cfg_wdata | input | MODE_W (3) | Write data |
| cpu_standby | input | 1 | CPU standby after wait-for-interrupt |
| wake_evt | input | 1 | Wakeup event |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_pwr_en | output | 1 | CPU core power enable |
| top_pwr_en | output | 1 | Top-domain power enable |
| aud_pwr_en | output | 1 | Audio-domain power enable |
| pll_en | output | 1 | PLL enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| rtc_clk_en | output | 1 | RTC clock enable |
| l2_pwr_en | output | 1 | L2 cache power enable |
| wake_done | output | 1 | One-cycle pulse at the end of a wakeup |
| cur_mode | output | 3 | Mode in force (0 while running) |

## Verification
The hardest point to reach from the ports is the gap between the register contents and the captured state. To get there, the bench enters DEEP-STOP and, while still asleep, rewrites both the stop configuration and the mode register. It then checks that the enables have not moved. After a full wakeup it enters again and checks that the new values now take effect. The restore sequence is followed one cycle at a time from a DEEP-STOP entry, where every phase gives a different enable pattern. This exposes an off-by-one in the settling count or a step taken out of order.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      PM_NORMAL = 3'd0,
      PM_IDLE   = 3'd1,
      PM_DIDLE  = 3'd2,
      PM_STOP   = 3'd3,
      PM_DSTOP  = 3'd4,
      PM_SLEEP  = 3'd5
   } pm_mode_e;

   typedef enum logic [2:0] {
      SQ_RUN,
      SQ_LOW,
      SQ_PWR,
      SQ_PLL,
      SQ_CLK
   } sq_state_e;

   typedef struct packed {
      logic [1:0] top;
      logic       l2_keep;
   } pm_cfg_t;

   // bit order here is the order of the packed enable vector
   typedef struct packed {
      logic cpu_clk;
      logic cpu_pwr;
      logic top_pwr;
      logic aud_pwr;
      logic pll;
      logic periph_clk;
      logic rtc_clk;
      logic l2_pwr;
   } pm_en_t;

   localparam logic [1:0] TOP_HOLD = 2'b01;
   localparam logic [1:0] TOP_LIVE = 2'b10;

   localparam pm_cfg_t CFG_RESET = '{top: TOP_LIVE, l2_keep: 1'b1};
   localparam pm_en_t  EN_ALL    = '{default: 1'b1};

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
   import lpm_pkg::*;
#(
   parameter int MODE_W = 3,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [MODE_W-1:0] wr_data,
   output logic [MODE_W-1:0] mode_q,
   output pm_cfg_t           idle_q,
   output pm_cfg_t           stop_q
);

   localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(0);
   localparam logic [SEL_W-1:0] SEL_IDLE = SEL_W'(1);
   localparam logic [SEL_W-1:0] SEL_STOP = SEL_W'(2);

   pm_cfg_t wr_cfg;
   assign wr_cfg = '{top: wr_data[1:0], l2_keep: wr_data[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         idle_q <= CFG_RESET;
         stop_q <= CFG_RESET;
      end else if (wr_en) begin
         if (wr_sel == SEL_MODE) mode_q <= wr_data;
         if (wr_sel == SEL_IDLE) idle_q <= wr_cfg;
         if (wr_sel == SEL_STOP) stop_q <= wr_cfg;
      end
   end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int MODE_W     = 3,
   parameter int SETTLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_standby,
   input  logic              wake_evt,
   input  logic [MODE_W-1:0] mode_req,
   input  pm_cfg_t           idle_cfg,
   input  pm_cfg_t           stop_cfg,
   output sq_state_e         state,
   output pm_mode_e          lat_mode,
   output pm_cfg_t           lat_cfg
);

   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             req_ok;

   assign req_ok = (mode_req >= MODE_W'(1)) && (mode_req <= MODE_W'(5));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_RUN;
         cnt      <= '0;
         lat_mode <= PM_NORMAL;
         lat_cfg  <= CFG_RESET;
      end else begin
         case (state)
            SQ_RUN: begin
               if (cpu_standby && req_ok) begin
                  state    <= SQ_LOW;
                  lat_mode <= pm_mode_e'(mode_req[2:0]);
                  lat_cfg  <= (mode_req[2:0] == 3'd2) ? idle_cfg : stop_cfg;
               end
            end
            SQ_LOW: begin
               if (wake_evt) begin
                  state <= SQ_PWR;
                  cnt   <= '0;
               end
            end
            SQ_PWR: begin
               if (cnt == CNT_LAST) state <= SQ_PLL;
               else                 cnt   <= cnt + 1'b1;
            end
            SQ_PLL:  state <= SQ_CLK;
            SQ_CLK:  state <= SQ_RUN;
            default: state <= SQ_RUN;
         endcase
      end
   end

endmodule

// File: rtl/lpm_map.sv
module lpm_map
   import lpm_pkg::*;
(
   input  sq_state_e state,
   input  pm_mode_e  lat_mode,
   input  pm_cfg_t   lat_cfg,
   output pm_en_t    en,
   output logic      done
);

   pm_en_t lp;
   pm_en_t pw;

   always_comb begin
      lp = EN_ALL;
      case (lat_mode)
         PM_IDLE: lp.cpu_clk = 1'b0;
         PM_DIDLE: begin
            lp.cpu_clk    = 1'b0;
            lp.cpu_pwr    = 1'b0;
            lp.periph_clk = (lat_cfg.top != TOP_HOLD);
            lp.l2_pwr     = lat_cfg.l2_keep;
         end
         PM_STOP: begin
            lp.cpu_clk    = 1'b0;
            lp.pll        = 1'b0;
            lp.periph_clk = 1'b0;
         end
         PM_DSTOP: begin
            lp.cpu_clk    = 1'b0;
            lp.cpu_pwr    = 1'b0;
            lp.aud_pwr    = 1'b0;
            lp.pll        = 1'b0;
            lp.periph_clk = 1'b0;
            lp.top_pwr    = (lat_cfg.top == TOP_LIVE);
            lp.l2_pwr     = lat_cfg.l2_keep;
         end
         PM_SLEEP: begin
            lp         = '0;
            lp.rtc_clk = 1'b1;
         end
         default: lp = EN_ALL;
      endcase
   end

   always_comb begin
      pw         = lp;
      pw.cpu_pwr = 1'b1;
      pw.top_pwr = 1'b1;
      pw.aud_pwr = 1'b1;
      pw.l2_pwr  = 1'b1;
   end

   always_comb begin
      done = 1'b0;
      case (state)
         SQ_LOW: en = lp;
         SQ_PWR: en = pw;
         SQ_PLL: begin
            en     = pw;
            en.pll = 1'b1;
         end
         SQ_CLK: begin
            en   = EN_ALL;
            done = 1'b1;
         end
         default: en = EN_ALL;
      endcase
   end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int MODE_W     = 3,
   parameter int SETTLE_CYC = 8,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [MODE_W-1:0] cfg_wdata,
   input  logic              cpu_standby,
   input  logic              wake_evt,
   output logic              cpu_clk_en,
   output logic              cpu_pwr_en,
   output logic              top_pwr_en,
   output logic              aud_pwr_en,
   output logic              pll_en,
   output logic              periph_clk_en,
   output logic              rtc_clk_en,
   output logic              l2_pwr_en,
   output logic              wake_done,
   output logic [2:0]        cur_mode
);

   if (MODE_W < 3) begin : g_bad_mode_w
      $error("lpm_ctrl: MODE_W must be at least 3");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("lpm_ctrl: SETTLE_CYC must be at least 1");
   end

   logic [MODE_W-1:0] mode_q;
   pm_cfg_t           idle_q, stop_q, lat_cfg;
   sq_state_e         state;
   pm_mode_e          lat_mode;
   pm_en_t            en_c, en_o;
   logic              done_c, done_o;

   lpm_regs #(.MODE_W(MODE_W), .SEL_W(2)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
      .wr_data(cfg_wdata), .mode_q(mode_q), .idle_q(idle_q), .stop_q(stop_q)
   );

   lpm_seq #(.MODE_W(MODE_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .cpu_standby(cpu_standby), .wake_evt(wake_evt),
      .mode_req(mode_q), .idle_cfg(idle_q), .stop_cfg(stop_q),
      .state(state), .lat_mode(lat_mode), .lat_cfg(lat_cfg)
   );

   lpm_map u_map (
      .state(state), .lat_mode(lat_mode), .lat_cfg(lat_cfg),
      .en(en_c), .done(done_c)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o   <= EN_ALL;
            done_o <= 1'b0;
         end else begin
            en_o   <= en_c;
            done_o <= done_c;
         end
      end
   end else begin : g_out_comb
      assign en_o   = en_c;
      assign done_o = done_c;
   end

   assign cpu_clk_en    = en_o.cpu_clk;
   assign cpu_pwr_en    = en_o.cpu_pwr;
   assign top_pwr_en    = en_o.top_pwr;
   assign aud_pwr_en    = en_o.aud_pwr;
   assign pll_en        = en_o.pll;
   assign periph_clk_en = en_o.periph_clk;
   assign rtc_clk_en    = en_o.rtc_clk;
   assign l2_pwr_en     = en_o.l2_pwr;
   assign wake_done     = done_o;
   assign cur_mode      = (state == SQ_RUN) ? 3'd0 : lat_mode;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_standby,
   input logic       cpu_clk_en,
   input logic       cpu_pwr_en,
   input logic       top_pwr_en,
   input logic       aud_pwr_en,
   input logic       pll_en,
   input logic       periph_clk_en,
   input logic       l2_pwr_en,
   input logic       wake_done,
   input logic [2:0] cur_mode
);

   assert_clk_needs_pwr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> cpu_pwr_en);

   assert_clk_needs_pll_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> (!periph_clk_en && !cpu_clk_en));

   assert_pwr_before_pll_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> (cpu_pwr_en && top_pwr_en && aud_pwr_en && l2_pwr_en));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |=> (!wake_done && cur_mode == 3'd0));

   assert_no_entry_wo_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd0 && !cpu_standby) |=> (cur_mode == 3'd0));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (.*);

// File: tb/lpm_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = 2'd0;
   logic [2:0] cfg_wdata = 3'd0;
   logic       cpu_standby = 1'b0;
   logic       wake_evt = 1'b0;
   logic       cpu_clk_en, cpu_pwr_en, top_pwr_en, aud_pwr_en;
   logic       pll_en, periph_clk_en, rtc_clk_en, l2_pwr_en;
   logic       wake_done;
   logic [2:0] cur_mode;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lpm_ctrl u_lpm_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cpu_standby(cpu_standby), .wake_evt(wake_evt),
      .cpu_clk_en(cpu_clk_en), .cpu_pwr_en(cpu_pwr_en), .top_pwr_en(top_pwr_en),
      .aud_pwr_en(aud_pwr_en), .pll_en(pll_en), .periph_clk_en(periph_clk_en),
      .rtc_clk_en(rtc_clk_en), .l2_pwr_en(l2_pwr_en), .wake_done(wake_done),
      .cur_mode(cur_mode)
   );

   // enable vector order: cpu_clk cpu_pwr top aud pll periph rtc l2
   function automatic logic [7:0] en_vec();
      return {cpu_clk_en, cpu_pwr_en, top_pwr_en, aud_pwr_en,
              pll_en, periph_clk_en, rtc_clk_en, l2_pwr_en};
   endfunction

   task automatic chk(string req, logic [7:0] exp_en, logic [2:0] exp_mode, logic exp_done);
      n_chk++;
      if (en_vec() !== exp_en || cur_mode !== exp_mode || wake_done !== exp_done) begin
         n_fail++;
         $display("FAIL %s: en=%h mode=%0d done=%b, expected en=%h mode=%0d done=%b",
                  req, en_vec(), cur_mode, wake_done, exp_en, exp_mode, exp_done);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [2:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic standby_pulse();
      @(negedge clk); cpu_standby = 1'b1;
      @(negedge clk); cpu_standby = 1'b0;
   endtask

   task automatic wake_pulse();
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
   endtask

   // wake from a low-power pattern lp, checking every restore phase
   task automatic wake_full(string req, logic [7:0] lp, logic [2:0] m);
      logic [7:0] pw;
      pw = lp | 8'h71;
      wake_pulse();
      chk(req, pw, m, 1'b0);
      repeat (7) @(negedge clk);
      chk(req, pw, m, 1'b0);
      @(negedge clk);
      chk(req, pw | 8'h08, m, 1'b0);
      @(negedge clk);
      chk(req, 8'hFF, m, 1'b1);
      @(negedge clk);
      chk(req, 8'hFF, 3'd0, 1'b0);
   endtask

   task automatic enter_check(string req, logic [2:0] m, logic [7:0] exp);
      wr(2'd0, m);
      standby_pulse();
      chk(req, exp, m, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1", 8'hFF, 3'd0, 1'b0);
   endtask

   task automatic t_no_entry();
      wr(2'd0, 3'd3);
      repeat (3) @(negedge clk);
      chk("R2 mode write without standby", 8'hFF, 3'd0, 1'b0);
      wr(2'd0, 3'd6);
      standby_pulse();
      chk("R2 code 6", 8'hFF, 3'd0, 1'b0);
      wr(2'd0, 3'd7);
      standby_pulse();
      chk("R2 code 7", 8'hFF, 3'd0, 1'b0);
      wr(2'd0, 3'd0);
      standby_pulse();
      chk("R2 code 0", 8'hFF, 3'd0, 1'b0);
      wake_pulse();
      chk("R10 wake in NORMAL", 8'hFF, 3'd0, 1'b0);
   endtask

   task automatic t_idle();
      enter_check("R3 idle", 3'd1, 8'h7F);
      standby_pulse();
      chk("R10 standby while low", 8'h7F, 3'd1, 1'b0);
      wake_full("R10 idle wake", 8'h7F, 3'd1);
   endtask

   task automatic t_deep_idle();
      wr(2'd1, 3'b101);
      enter_check("R4 deep-idle hold l2 on", 3'd2, 8'h3B);
      wake_full("R10 deep-idle wake", 8'h3B, 3'd2);
      wr(2'd1, 3'b001);
      enter_check("R4 deep-idle hold l2 off", 3'd2, 8'h3A);
      wake_full("R10", 8'h3A, 3'd2);
      wr(2'd1, 3'b110);
      enter_check("R5 deep-idle live", 3'd2, 8'h3F);
      wake_full("R10", 8'h3F, 3'd2);
      wr(2'd1, 3'b100);
      enter_check("R5 deep-idle reserved 00", 3'd2, 8'h3F);
      wake_full("R10", 8'h3F, 3'd2);
      wr(2'd1, 3'b011);
      enter_check("R5 deep-idle reserved 11", 3'd2, 8'h3E);
      wake_full("R10", 8'h3E, 3'd2);
   endtask

   task automatic t_stop();
      wr(2'd2, 3'b001);
      enter_check("R6 stop", 3'd3, 8'h73);
      wake_full("R10 stop wake", 8'h73, 3'd3);
   endtask

   task automatic t_deep_stop();
      wr(2'd2, 3'b110);
      enter_check("R7 deep-stop top live", 3'd4, 8'h23);
      wake_full("R10 deep-stop wake", 8'h23, 3'd4);
      wr(2'd2, 3'b001);
      enter_check("R7 deep-stop top gated", 3'd4, 8'h02);
      wake_full("R10 deep-stop wake gated", 8'h02, 3'd4);
      wr(2'd2, 3'b111);
      enter_check("R7 deep-stop reserved 11", 3'd4, 8'h03);
      wake_full("R10", 8'h03, 3'd4);
      wr(2'd2, 3'b000);
      enter_check("R7 deep-stop reserved 00", 3'd4, 8'h02);
      wake_full("R10", 8'h02, 3'd4);
   endtask

   task automatic t_sleep();
      wr(2'd1, 3'b110);
      wr(2'd2, 3'b110);
      enter_check("R8 sleep", 3'd5, 8'h02);
      wake_full("R10 sleep wake", 8'h02, 3'd5);
   endtask

   task automatic t_capture();
      wr(2'd2, 3'b110);
      enter_check("R9 entry", 3'd4, 8'h23);
      wr(2'd2, 3'b001);
      wr(2'd0, 3'd5);
      @(negedge clk);
      chk("R9 writes while low", 8'h23, 3'd4, 1'b0);
      wake_full("R10", 8'h23, 3'd4);
      standby_pulse();
      chk("R9 new values on next entry", 8'h02, 3'd5, 1'b0);
      wake_full("R10", 8'h02, 3'd5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_entry();
      t_idle();
      t_deep_idle();
      t_stop();
      t_deep_stop();
      t_sleep();
      t_capture();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule